// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a general-purpose I/O controller with one pin per bit of its register width. It holds an output latch and a direction store, drives the pads with registered values, and brings the pad inputs through a two-flop synchronizer before software can see them. Software reaches it over a simple synchronous register bus: a write strobe, a read strobe, a two-bit register index and a data word as wide as the register. Read data appears on `bus_rdata` one clock after the read strobe and holds until the next read.

The register index selects one of four slots: 0 is the data view, 1 is the set register, 2 is the clear register and 3 is the direction register. Build parameters choose how software updates the latch, which polarity the direction register has (or whether it exists), whether reading the set register returns the latch for output pins, and how bus bits map onto pins. Pin numbering can be reversed inside the word, and byte order on the bus can be swapped for 16- and 32-bit builds. Illegal parameter sets stop elaboration: a width other than 8, 16, 32 or 64, both direction polarities at once, a byte swap in a 64-bit build, or an unknown latch model.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: With `OUT_MODEL`=0 (data only), a write to index 0 loads the whole output latch onto `pad_out` after one clock edge. Writes to index 1 or 2 leave `pad_out` unchanged, and reading index 1 returns zero.
- R2: With `OUT_MODEL`=1 (set/clear pair), each 1 written to index 1 drives that pin's latch bit high and each 1 written to index 2 drives it low. 0 bits leave the latch unchanged, and writes to index 0 are ignored.
- R3: With `OUT_MODEL`=2 (separate output), a write to index 1 replaces the whole latch rather than OR-ing into it. Writes to index 0 and index 2 are ignored.
- R4: A read of index 0 returns the pad inputs after a two-flop synchronizer. A read captured on the first clock edge after a pad change still returns the old value, and the new value is returned once two edges have passed.
- R5: With `HAS_OUT_DIR`=1, a 1 in the direction register enables that pin's output (`pad_oe` bit 1) and a 0 makes it an input. Reading index 3 returns the stored direction bits.
- R6: With `HAS_IN_DIR`=1, the direction polarity is inverted: a 1 makes the pin an input and a 0 makes it an output. Setting both `HAS_OUT_DIR` and `HAS_IN_DIR` is rejected at elaboration.
- R7: With neither direction register, `pad_oe` is all ones, writes to index 3 have no effect, and index 3 reads as zero.
- R8: With `READBACK`=1, reading index 1 returns the latch bit for pins whose output is enabled and the synchronized pad bit for input pins. With `READBACK`=0, or with no set register, index 1 reads as zero. Index 2 always reads as zero.
- R9: With `BIT_BE`=1, register bit b corresponds to pin `WIDTH-1-b` for both writes and reads. With `BIT_BE`=0, register bit b is pin b.
- R10: With `BYTE_BE`=1, byte k of the bus word is byte `WIDTH/8-1-k` of the register, in both directions. This option is rejected at elaboration for `WIDTH`=64.
- R11: Synchronous reset clears the output latch and `bus_rdata`. It makes every pin an input: the direction store is cleared for output polarity and set to all ones for input polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register index: 0 data, 1 set, 2 clear, 3 direction |
| bus_wdata | input | WIDTH | Write data in bus byte order |
| bus_rdata | output | WIDTH | Registered read data in bus byte order |
| pad_in | input | WIDTH | Pad input levels, asynchronous |
| pad_out | output | WIDTH | Registered output latch, indexed by pin |
| pad_oe | output | WIDTH | Registered per-pin output enable |

## Verification
The bench builds three instances side by side. The first is 16 bits wide with the set/clear model, input-polarity direction, readback, reversed bit numbering and swapped bytes. The second is 8 bits wide with the data-only model and output-polarity direction. The third is 32 bits wide with the separate-output model, no direction register and readback. Together they reach every latch model and every direction option. The combined bit and byte remapping appears in the first instance as a per-byte bit reversal. The readback mix of latch and pad bits is checked with some pins set as outputs and others as inputs.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_SET  = 2'd1,
    REG_CLR  = 2'd2,
    REG_DIR  = 2'd3
  } gpio_reg_e;

  localparam int OUT_DATA_ONLY = 0;
  localparam int OUT_SET_CLR   = 1;
  localparam int OUT_SEPARATE  = 2;

endpackage

// File: rtl/gpio_lane_map.sv
module gpio_lane_map #(
  parameter int WIDTH   = 32,
  parameter bit BIT_BE  = 1'b0,
  parameter bit BYTE_BE = 1'b0,
  parameter bit TO_PINS = 1'b1
) (
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int NBYTES = WIDTH / 8;

  logic [WIDTH-1:0] swap_in, swap_out, rev_in, rev_out;

  generate
    if (TO_PINS) begin : g_to_pins
      assign swap_in = d;
      assign rev_in  = swap_out;
      assign q       = rev_out;
    end else begin : g_to_bus
      assign rev_in  = d;
      assign swap_in = rev_out;
      assign q       = swap_out;
    end

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
      if (BYTE_BE) begin : g_swap
        assign swap_out[8*k +: 8] = swap_in[8*(NBYTES-1-k) +: 8];
      end else begin : g_keep
        assign swap_out[8*k +: 8] = swap_in[8*k +: 8];
      end
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      if (BIT_BE) begin : g_rev
        assign rev_out[b] = rev_in[WIDTH-1-b];
      end else begin : g_fwd
        assign rev_out[b] = rev_in[b];
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int WIDTH     = 32,
  parameter int OUT_MODEL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_data,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [WIDTH-1:0] val,
  output logic [WIDTH-1:0] latch_q
);
  import gpio_pkg::*;

  logic [WIDTH-1:0] raise_m, drop_m, nxt;

  always_comb begin
    raise_m = wr_set ? val : '0;
    drop_m  = wr_clr ? val : '0;
    nxt     = latch_q;
    case (OUT_MODEL)
      OUT_DATA_ONLY: if (wr_data) nxt = val;
      OUT_SET_CLR:   nxt = (latch_q | raise_m) & ~drop_m;
      default:       if (wr_set) nxt = val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) latch_q <= '0;
    else     latch_q <= nxt;
  end
endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
  parameter int WIDTH   = 32,
  parameter bit IN_HIGH = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [WIDTH-1:0] val,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] oe_q
);
  localparam logic [WIDTH-1:0] DIR_RESET = IN_HIGH ? '1 : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_RESET;
      oe_q  <= '0;
    end else if (wr) begin
      dir_q <= val;
      oe_q  <= IN_HIGH ? ~val : val;
    end
  end
endmodule

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl #(
  parameter int WIDTH       = 32,
  parameter int OUT_MODEL   = 0,
  parameter bit HAS_OUT_DIR = 1'b1,
  parameter bit HAS_IN_DIR  = 1'b0,
  parameter bit READBACK    = 1'b0,
  parameter bit BIT_BE      = 1'b0,
  parameter bit BYTE_BE     = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  import gpio_pkg::*;

  localparam bit HAS_SET_REG = (OUT_MODEL != OUT_DATA_ONLY);
  localparam bit SET_VISIBLE = READBACK && HAS_SET_REG;

  generate
    if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
      $error("gpio_mmio_ctrl: WIDTH must be 8, 16, 32 or 64");
    end
    if (HAS_OUT_DIR && HAS_IN_DIR) begin : g_bad_dir
      $error("gpio_mmio_ctrl: output and input direction polarity both enabled");
    end
    if (BYTE_BE && WIDTH == 64) begin : g_bad_swap
      $error("gpio_mmio_ctrl: byte swap not available at 64 bits");
    end
    if (OUT_MODEL < 0 || OUT_MODEL > 2) begin : g_bad_model
      $error("gpio_mmio_ctrl: OUT_MODEL must be 0, 1 or 2");
    end
  endgenerate

  logic [WIDTH-1:0] wr_pins, rd_pins, rd_bus;
  logic [WIDTH-1:0] sync_q, latch_q, dir_q, oe_q;
  logic             wr_data, wr_set, wr_clr;

  assign wr_data = bus_wr && (bus_addr == REG_DATA);
  assign wr_set  = bus_wr && (bus_addr == REG_SET);
  assign wr_clr  = bus_wr && (bus_addr == REG_CLR);

  gpio_lane_map #(
    .WIDTH(WIDTH), .BIT_BE(BIT_BE), .BYTE_BE(BYTE_BE), .TO_PINS(1'b1)
  ) u_wmap (
    .d(bus_wdata),
    .q(wr_pins)
  );

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst(rst), .async_in(pad_in), .sync_out(sync_q)
  );

  gpio_out_latch #(.WIDTH(WIDTH), .OUT_MODEL(OUT_MODEL)) u_latch (
    .clk(clk), .rst(rst),
    .wr_data(wr_data), .wr_set(wr_set), .wr_clr(wr_clr),
    .val(wr_pins), .latch_q(latch_q)
  );

  generate
    if (HAS_OUT_DIR || HAS_IN_DIR) begin : g_dir
      logic wr_dir;
      assign wr_dir = bus_wr && (bus_addr == REG_DIR);
      gpio_dir_reg #(.WIDTH(WIDTH), .IN_HIGH(HAS_IN_DIR)) u_dir (
        .clk(clk), .rst(rst), .wr(wr_dir), .val(wr_pins),
        .dir_q(dir_q), .oe_q(oe_q)
      );
    end else begin : g_nodir
      assign dir_q = '0;
      assign oe_q  = '1;
    end
  endgenerate

  always_comb begin
    case (bus_addr)
      REG_DATA: rd_pins = sync_q;
      REG_SET:  rd_pins = SET_VISIBLE ? ((oe_q & latch_q) | (~oe_q & sync_q)) : '0;
      REG_CLR:  rd_pins = '0;
      default:  rd_pins = dir_q;
    endcase
  end

  gpio_lane_map #(
    .WIDTH(WIDTH), .BIT_BE(BIT_BE), .BYTE_BE(BYTE_BE), .TO_PINS(1'b0)
  ) u_rmap (
    .d(rd_pins),
    .q(rd_bus)
  );

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_bus;
  end

  assign pad_out = latch_q;
  assign pad_oe  = oe_q;
endmodule

// File: rtl/gpio_mmio_chk.sv
module gpio_mmio_chk #(
  parameter int WIDTH     = 32,
  parameter int OUT_MODEL = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [1:0]       bus_addr,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (pad_out == '0 && bus_rdata == '0)); // R11

  AST_IDLE_HOLDS_LATCH: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(pad_out)); // R1

  AST_OE_ONLY_ON_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 2'd3) |=> $stable(pad_oe)); // R5

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R4

  generate
    if (OUT_MODEL == 1) begin : g_sc
      AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd1) |=> ((pad_out & $past(pad_out)) == $past(pad_out))); // R2
      AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd2) |=> ((pad_out & ~$past(pad_out)) == '0)); // R2
    end
    if (OUT_MODEL != 0) begin : g_nodata
      AST_DATA_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0) |=> $stable(pad_out)); // R3
    end
  endgenerate
endmodule

bind gpio_mmio_ctrl gpio_mmio_chk #(.WIDTH(WIDTH), .OUT_MODEL(OUT_MODEL)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/sim_gpio_mmio_ctrl.sv
module sim_gpio_mmio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  // {index[49:48], bus word[47:32], expected pad_out[31:16], expected pad_oe[15:0]}
  // Instance u0: bit reversal plus byte swap acts as a bit reversal inside each byte.
  localparam logic [49:0] VEC [NVEC] = '{
    {2'd3, 16'h00FF, 16'h0000, 16'hFF00},
    {2'd1, 16'h0100, 16'h8000, 16'hFF00},
    {2'd1, 16'h0001, 16'h8080, 16'hFF00},
    {2'd1, 16'h0000, 16'h8080, 16'hFF00},
    {2'd2, 16'h0100, 16'h0080, 16'hFF00},
    {2'd2, 16'h0000, 16'h0080, 16'hFF00},
    {2'd0, 16'hFFFF, 16'h0080, 16'hFF00},
    {2'd1, 16'hF00F, 16'h0FF0, 16'hFF00},
    {2'd2, 16'h0F0F, 16'h0F00, 16'hFF00},
    {2'd3, 16'hFFFF, 16'h0F00, 16'h0000},
    {2'd3, 16'h0000, 16'h0F00, 16'hFFFF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd = 1'b0, we0 = 1'b0, we1 = 1'b0, we2 = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [15:0] pin0 = '0;
  logic [7:0]  pin1 = '0;
  logic [31:0] pin2 = '0;
  logic [15:0] rdata0, out0, oe0;
  logic [7:0]  rdata1, out1, oe1;
  logic [31:0] rdata2, out2, oe2;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mmio_ctrl #(.WIDTH(16), .OUT_MODEL(1), .HAS_OUT_DIR(1'b0), .HAS_IN_DIR(1'b1),
    .READBACK(1'b1), .BIT_BE(1'b1), .BYTE_BE(1'b1)) u0 (
    .clk(clk), .rst(rst), .bus_wr(we0), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata[15:0]), .bus_rdata(rdata0), .pad_in(pin0),
    .pad_out(out0), .pad_oe(oe0));

  gpio_mmio_ctrl #(.WIDTH(8), .OUT_MODEL(0), .HAS_OUT_DIR(1'b1), .HAS_IN_DIR(1'b0),
    .READBACK(1'b0), .BIT_BE(1'b0), .BYTE_BE(1'b0)) u1 (
    .clk(clk), .rst(rst), .bus_wr(we1), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata[7:0]), .bus_rdata(rdata1), .pad_in(pin1),
    .pad_out(out1), .pad_oe(oe1));

  gpio_mmio_ctrl #(.WIDTH(32), .OUT_MODEL(2), .HAS_OUT_DIR(1'b0), .HAS_IN_DIR(1'b0),
    .READBACK(1'b1), .BIT_BE(1'b0), .BYTE_BE(1'b0)) u2 (
    .clk(clk), .rst(rst), .bus_wr(we2), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata2), .pad_in(pin2),
    .pad_out(out2), .pad_oe(oe2));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int which, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    we0 = (which == 0); we1 = (which == 1); we2 = (which == 2);
    @(negedge clk);
    we0 = 1'b0; we1 = 1'b0; we2 = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 u0 pad_out", {16'h0, out0}, 32'h0);
    check("R11 u0 pad_oe all inputs (input polarity)", {16'h0, oe0}, 32'h0);
    check("R11 u1 pad_oe all inputs (output polarity)", {24'h0, oe1}, 32'h0);
    check("R11 u0 bus_rdata", {16'h0, rdata0}, 32'h0);
    check("R7 u2 pad_oe with no direction register", oe2, 32'hFFFF_FFFF);

    // Vector table on u0: R2 set/clear, R6 polarity, R9/R10 lane mapping
    for (int i = 0; i < NVEC; i++) begin
      wr(0, VEC[i][49:48], {16'h0, VEC[i][47:32]});
      check($sformatf("R2/R9/R10 vec %0d pad_out", i), {16'h0, out0}, {16'h0, VEC[i][31:16]});
      check($sformatf("R6 vec %0d pad_oe", i), {16'h0, oe0}, {16'h0, VEC[i][15:0]});
    end

    // R8 readback on u0, all pins outputs now, latch pins = 0F00
    pin0 = 16'h5555;
    repeat (3) @(negedge clk);
    rdreg(2'd1);
    check("R8 u0 set read all outputs", {16'h0, rdata0}, 32'h0000_F000);
    rdreg(2'd0);
    check("R4/R10 u0 data read pads", {16'h0, rdata0}, 32'h0000_AAAA);
    wr(0, 2'd3, 32'h0000_00FF);
    rdreg(2'd1);
    check("R8 u0 set read mixed latch/pad", {16'h0, rdata0}, 32'h0000_F0AA);
    rdreg(2'd3);
    check("R6 u0 direction read", {16'h0, rdata0}, 32'h0000_00FF);
    rdreg(2'd2);
    check("R8 u0 clear read zero", {16'h0, rdata0}, 32'h0);

    // u1: data only, output polarity
    wr(1, 2'd0, 32'hA5);
    check("R1 u1 data write loads latch", {24'h0, out1}, 32'hA5);
    check("R5 u1 oe before direction write", {24'h0, oe1}, 32'h0);
    wr(1, 2'd3, 32'h0F);
    check("R5 u1 oe follows direction", {24'h0, oe1}, 32'h0F);
    wr(1, 2'd1, 32'hFF);
    check("R1 u1 set write ignored", {24'h0, out1}, 32'hA5);
    wr(1, 2'd2, 32'hFF);
    check("R1 u1 clear write ignored", {24'h0, out1}, 32'hA5);
    rdreg(2'd1);
    check("R1/R8 u1 set reads zero", {24'h0, rdata1}, 32'h0);
    rdreg(2'd3);
    check("R5 u1 direction read", {24'h0, rdata1}, 32'h0F);
    pin1 = 8'h3C;
    repeat (3) @(negedge clk);
    rdreg(2'd0);
    check("R4 u1 data read", {24'h0, rdata1}, 32'h3C);
    // R4 synchronizer latency: change pad and read on the same edge
    @(negedge clk);
    pin1 = 8'hC3; addr = 2'd0; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check("R4 u1 read one edge after pad change is old", {24'h0, rdata1}, 32'h3C);
    repeat (2) @(negedge clk);
    rdreg(2'd0);
    check("R4 u1 read after two edges is new", {24'h0, rdata1}, 32'hC3);

    // u2: separate output, no direction, readback
    wr(2, 2'd1, 32'hDEAD_BEEF);
    check("R3 u2 set write loads latch", out2, 32'hDEAD_BEEF);
    wr(2, 2'd0, 32'h1234_5678);
    check("R3 u2 data write ignored", out2, 32'hDEAD_BEEF);
    wr(2, 2'd2, 32'hFFFF_FFFF);
    check("R3 u2 clear write ignored", out2, 32'hDEAD_BEEF);
    wr(2, 2'd3, 32'h0);
    check("R7 u2 direction write ignored", oe2, 32'hFFFF_FFFF);
    rdreg(2'd3);
    check("R7 u2 direction reads zero", rdata2, 32'h0);
    rdreg(2'd1);
    check("R8 u2 set read returns latch", rdata2, 32'hDEAD_BEEF);
    wr(2, 2'd1, 32'h0000_0001);
    check("R3 u2 set write replaces latch", out2, 32'h0000_0001);
    pin2 = 32'hCAFE_F00D;
    repeat (3) @(negedge clk);
    rdreg(2'd0);
    check("R4/R9 u2 data read unmapped", rdata2, 32'hCAFE_F00D);

    // R11 reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R11 u0 latch after reset", {16'h0, out0}, 32'h0);
    check("R11 u0 oe after reset", {16'h0, oe0}, 32'h0);
    check("R11 u1 oe after reset", {24'h0, oe1}, 32'h0);
    check("R11 u2 latch after reset", out2, 32'h0);
    rdreg(2'd3);
    check("R11 u0 direction all ones after reset", {16'h0, rdata0}, 32'h0000_FFFF);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule